// File: doc/BRIEF.md
# Tagged Shared Refill Response Buffer

This block is a small first-in first-out buffer that sits between a memory response channel and several cache instances that are refilling lines. Each refill word arrives with the index of the cache that will consume it. The word and its owner index are stored together in one entry. Only the oldest entry is ever exposed.

On the read side, every cache gets its own valid bit. That bit is raised only when the buffer holds at least one word and the owner index of the oldest entry equals that cache's index. All caches see the same head data word. A cache removes the head by raising its own pop bit. A pop from any other cache, or a pop while the buffer is empty, changes nothing.

The push side accepts a word only while fewer than `DEPTH` entries are held. A synchronous flush input, like reset, discards all pending entries.

Top module: `refill_tag_fifo`

## Requirements
- R1: After reset, all bits of `head_valid` are 0 and `push_ready` is 1.
- R2: `push_ready` is 1 exactly when fewer than `DEPTH` (default 2) entries are held. A push offered while `push_ready` is 0 is not stored.
- R3: When the buffer is non-empty, `head_valid` has exactly one bit set, at position `tag` of the oldest entry (bit i belongs to cache index i). When the buffer is empty, `head_valid` is all zero.
- R4: `head_data` shows the oldest stored word, and words leave in the order they were accepted.
- R5: A pop whose bit position matches a set `head_valid` bit removes exactly the head entry.
- R6: A pop from a cache whose `head_valid` bit is 0 (wrong owner, or buffer empty) is ignored. Contents, `head_data` and `head_valid` are unchanged.
- R7: An accepted push and a valid pop in the same cycle are both performed, and occupancy is unchanged.
- R8: `flush` empties the buffer on the next clock edge. A push offered in the same cycle as `flush` is discarded.
- R9: Every word keeps the owner index it was pushed with, including when consecutive words carry different indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Synchronous discard of all entries |
| push_valid | input | 1 | A refill word is offered |
| push_tag | input | TAG_W | Owner cache index of the offered word |
| push_data | input | DATA_W | Offered refill word |
| push_ready | output | 1 | Buffer can accept a word this cycle |
| head_valid | output | NUM_CACHES | Per-cache flag: head entry belongs to this cache |
| head_data | output | DATA_W | Oldest stored word |
| pop | input | NUM_CACHES | Per-cache request to remove the head |

## Verification
Two functions can fall in the same cycle: an accepted push and an owner pop, and a push together with a flush. The bench provokes the first by holding one entry, then driving a new word and the owner's pop on one edge. It judges the result by checking that the new word becomes the head with its own owner bit set and that `push_ready` stays 1. It provokes the second by offering a word on the flush cycle and checking that the buffer reads empty afterwards.

// File: rtl/refill_tag_fifo.sv
module refill_tag_fifo #(
  parameter int NUM_CACHES = 4,
  parameter int DATA_W     = 32,
  parameter int DEPTH      = 2,
  parameter int TAG_W      = (NUM_CACHES > 1) ? $clog2(NUM_CACHES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush,
  input  logic                  push_valid,
  input  logic [TAG_W-1:0]      push_tag,
  input  logic [DATA_W-1:0]     push_data,
  output logic                  push_ready,
  output logic [NUM_CACHES-1:0] head_valid,
  output logic [DATA_W-1:0]     head_data,
  input  logic [NUM_CACHES-1:0] pop
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] data_q [DEPTH];
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [PTR_W-1:0]  rd_q, wr_q;
  logic [CNT_W-1:0]  cnt_q;

  logic push_fire, pop_fire, not_empty;

  assign not_empty  = (cnt_q != '0);
  assign push_ready = (cnt_q < CNT_W'(DEPTH));
  assign push_fire  = push_valid & push_ready & ~flush;
  assign pop_fire   = |(pop & head_valid) & ~flush;
  assign head_data  = data_q[rd_q];

  for (genvar i = 0; i < NUM_CACHES; i++) begin : g_own
    assign head_valid[i] = not_empty && (tag_q[rd_q] == TAG_W'(i));
  end

  function automatic logic [PTR_W-1:0] wrap_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
      if (!rst_n) begin
        for (int k = 0; k < DEPTH; k++) begin
          data_q[k] <= '0;
          tag_q[k]  <= '0;
        end
      end
    end else begin
      if (push_fire) begin
        data_q[wr_q] <= push_data;
        tag_q[wr_q]  <= push_tag;
        wr_q         <= wrap_inc(wr_q);
      end
      if (pop_fire) rd_q <= wrap_inc(rd_q);
      case ({push_fire, pop_fire})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/refill_tag_fifo_chk.sv
module refill_tag_fifo_chk #(
  parameter int NUM_CACHES = 4,
  parameter int DATA_W     = 32,
  parameter int TAG_W      = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush,
  input logic                  push_valid,
  input logic                  push_ready,
  input logic [NUM_CACHES-1:0] head_valid,
  input logic [DATA_W-1:0]     head_data,
  input logic [NUM_CACHES-1:0] pop
);
  // R3
  head_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(head_valid));

  // R8
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (head_valid == '0) && push_ready);

  // R5
  pop_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pop & head_valid)) && !flush |=> push_ready);

  // R6
  stray_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pop & head_valid) == '0) && !push_valid && !flush
      |=> $stable(head_valid) && $stable(head_data) && $stable(push_ready));

  // R7
  push_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_ready && (|(pop & head_valid)) && !flush
      |=> $stable(push_ready) && (head_valid != '0));
endmodule

bind refill_tag_fifo refill_tag_fifo_chk #(
  .NUM_CACHES(NUM_CACHES), .DATA_W(DATA_W), .TAG_W(TAG_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
  .push_ready(push_ready), .head_valid(head_valid), .head_data(head_data),
  .pop(pop)
);

// File: tb/refill_tag_fifo_tb_top.sv
module refill_tag_fifo_tb_top;
  localparam int NC = 4;
  localparam int DW = 32;
  localparam int TW = 2;
  localparam int DP = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic push_valid = 1'b0;
  logic [TW-1:0] push_tag = '0;
  logic [DW-1:0] push_data = '0;
  logic push_ready;
  logic [NC-1:0] head_valid;
  logic [DW-1:0] head_data;
  logic [NC-1:0] pop = '0;

  int checks = 0;
  int errors = 0;
  logic [TW+DW-1:0] exp_q[$];

  always #4 clk = ~clk;

  refill_tag_fifo #(.NUM_CACHES(NC), .DATA_W(DW), .DEPTH(DP), .TAG_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .flush(flush), .push_valid(push_valid),
    .push_tag(push_tag), .push_data(push_data), .push_ready(push_ready),
    .head_valid(head_valid), .head_data(head_data), .pop(pop)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor-side comparison of the head against the scoreboard
  task automatic check_head(input string req);
    if (exp_q.size() == 0) begin
      chk(head_valid == '0, req, head_valid, 0);
    end else begin
      logic [NC-1:0] ev;
      ev = NC'(1) << exp_q[0][TW+DW-1:DW];
      chk(head_valid == ev, req, head_valid, ev);
      chk(head_data == exp_q[0][DW-1:0], req, head_data, exp_q[0][DW-1:0]);
    end
    chk(push_ready == (exp_q.size() < DP), {req, " ready"}, push_ready, exp_q.size() < DP);
  endtask

  // driver: one cycle of optional push, pop bits and flush
  task automatic step(input bit pv, input logic [TW-1:0] t, input logic [DW-1:0] d,
                      input logic [NC-1:0] p, input bit fl);
    bit acc, hit;
    @(negedge clk);
    push_valid = pv; push_tag = t; push_data = d; pop = p; flush = fl;
    acc = pv && push_ready && !fl;
    hit = (p & head_valid) != '0 && !fl;
    @(posedge clk);
    #1;
    push_valid = 1'b0; pop = '0; flush = 1'b0;
    if (fl) exp_q.delete();
    else begin
      if (hit) void'(exp_q.pop_front());
      if (acc) exp_q.push_back({t, d});
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(head_valid == '0, "R1", head_valid, 0);
    chk(push_ready == 1'b1, "R1", push_ready, 1);

    // R3 R4 single word owned by cache 2
    step(1, 2'd2, 32'hA000_0001, '0, 0);
    check_head("R3");
    // R9 second word with a different owner; R2 now full
    step(1, 2'd0, 32'hB000_0002, '0, 0);
    check_head("R2");
    chk(push_ready == 1'b0, "R2", push_ready, 0);
    // R2 push while full is dropped
    step(1, 2'd1, 32'hC000_0003, '0, 0);
    check_head("R2");
    // R6 pop by non-owner
    step(0, '0, '0, 4'b1011, 0);
    check_head("R6");
    chk(head_data == 32'hA000_0001, "R6", head_data, 32'hA000_0001);
    // R5 owner pop; R9 next head owned by cache 0
    step(0, '0, '0, 4'b0100, 0);
    check_head("R5");
    chk(head_valid == 4'b0001, "R9", head_valid, 4'b0001);
    // R7 push and owner pop together
    step(1, 2'd3, 32'hD000_0004, 4'b0001, 0);
    check_head("R7");
    chk(push_ready == 1'b1, "R7", push_ready, 1);
    // R8 flush with concurrent push
    step(1, 2'd1, 32'hE000_0005, '0, 1);
    check_head("R8");
    chk(head_valid == '0, "R8", head_valid, 0);
    // R6 pop while empty
    step(0, '0, '0, 4'b1111, 0);
    check_head("R6");
    step(1, 2'd1, 32'hF000_0006, '0, 0);
    check_head("R4");

    // stream of mixed-owner words, drained in order (R4 R9)
    for (int i = 0; i < 40; i++) begin
      logic [TW-1:0] tg;
      tg = TW'((i * 7 + 3) % NC);
      if (exp_q.size() == DP) step(0, '0, '0, NC'(1) << exp_q[0][TW+DW-1:DW], 0);
      else step(1, tg, 32'h1000_0000 + i * 32'h11, '0, 0);
      check_head("R4");
    end
    while (exp_q.size() != 0) begin
      step(0, '0, '0, NC'(1) << exp_q[0][TW+DW-1:DW], 0);
      check_head("R9");
    end

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule